// File: doc/BRIEF.md
# Register-Mapped I2C Identification-ROM Byte Access Controller

This block gives a host single-byte read and write access to a small identification EEPROM on an I2C bus, through a few memory-mapped registers. The host writes a control word that holds the EEPROM word address in its low byte and the transfer direction in its top bit. It then either waits for a read to finish or writes the byte to be stored. The controller runs the whole bus transaction as the only master. It generates open-drain SCL and SDA from a programmable divider, and it ends every transaction with a one-cycle completion interrupt, so software never polls bus-level state.

A read is a random read: START, device address with write, word address, repeated START, device address with read, one byte, NACK from the master, STOP. A write is START, device address with write, word address, data byte, STOP. If the slave fails to acknowledge any byte the master sends, the controller aborts with a STOP, latches a sticky error flag and still raises the interrupt. The 7-bit device address and the quarter-bit divider are parameters.

Top module: `idrom_access`

## Requirements
- R1: After reset the status word is 0, irq is 0, both sclOe and sdaOe are 0, and the address and data registers read 0.
- R2: Register select 0 is the address register. A write to it while idle with bit 31 = 0 starts a random read: START, (DEV_ADDR<<1)|0, address bits 7:0, repeated START, (DEV_ADDR<<1)|1, one byte received, NACK from the master, STOP.
- R3: When a read completes, the data register (select 1) reads {24'b0, received byte}. Until then it keeps its previous contents.
- R4: An address write with bit 31 = 1 stores the address and starts nothing. A later data-register write then starts START, (DEV_ADDR<<1)|0, address bits 7:0, data bits 7:0, STOP. A data-register write while the stored bit 31 is 0 only stores the value.
- R5: Status (select 2) bit 0 is busy. It reads 1 from the cycle after the starting write until the transaction completes. Select 3 reads 0.
- R6: While busy, writes to the address, data and status registers are ignored.
- R7: If the slave NACKs any byte the master sends, the controller issues STOP and sets status bit 1 (error), and irq still pulses. The data register is left unchanged.
- R8: The error bit is sticky. Only a status write with bit 1 = 1 while idle clears it.
- R9: irq is a single-cycle pulse in the first cycle in which busy reads 0, after the STOP condition has been driven.
- R10: The outputs are open-drain enables (1 pulls the line low). Both are 0 while idle, and the master changes SDA during byte bits only while it holds SCL low.
- R11: When a slave holds SCL low after the master releases it, the master waits before sampling and continues correctly once SCL rises.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Active-low synchronous reset |
| busWr | input | 1 | Register write strobe |
| busSel | input | 2 | Register select: 0 address, 1 data, 2 status, 3 none |
| busWrData | input | 32 | Register write data |
| busRdData | output | 32 | Register read data for busSel (combinational) |
| sclIn | input | 1 | Sensed SCL line level |
| sdaIn | input | 1 | Sensed SDA line level |
| sclOe | output | 1 | Pull SCL low when 1 |
| sdaOe | output | 1 | Pull SDA low when 1 |
| irq | output | 1 | One-cycle completion pulse |

## Verification
Assertions check on every cycle that both lines stay released while idle, that SDA moves during data bits only under a low SCL, that the interrupt is a lone pulse with busy already low, that the error flag stays set until a clear, that the address register stays frozen while busy, and that a stretched clock holds the sampling phase. The correct byte order on the wire, the repeated START of a read, the returned data, the EEPROM contents after a write, and the abort paths on a NACK of the address or the data byte can only be shown by the bench's slave model across its directed and random scenarios.

// File: rtl/idrom_pkg.sv
package idrom_pkg;

  localparam logic [1:0] SEL_ADDR = 2'd0;
  localparam logic [1:0] SEL_DATA = 2'd1;
  localparam logic [1:0] SEL_STAT = 2'd2;
  localparam logic [1:0] SEL_NONE = 2'd3;

  typedef enum logic [1:0] {
    BYTE_DEVW = 2'd0,
    BYTE_WORD = 2'd1,
    BYTE_DEVR = 2'd2,
    BYTE_DATA = 2'd3
  } byteKind_e;

  typedef enum logic [1:0] {
    PH_IDLE  = 2'd0,
    PH_START = 2'd1,
    PH_BITS  = 2'd2,
    PH_STOP  = 2'd3
  } phase_e;

  typedef struct packed {
    logic      wrAddr;
    logic      wrData;
    logic      clrErr;
    logic      setErr;
    logic      loadShift;
    byteKind_e byteSel;
    logic      shiftOut;
    logic      shiftIn;
    logic      storeRx;
    logic      sclLow;
    logic      sclRel;
    logic      sdaLow;
    logic      sdaRel;
    logic      sdaFromShift;
    logic      done;
    logic      run;
  } ctlStrobe_t;

endpackage

// File: rtl/idrom_datapath.sv
module idrom_datapath
  import idrom_pkg::*;
#(
  parameter logic [6:0] DEV_ADDR = 7'h50,
  parameter int         SCL_DIV  = 125
) (
  input  logic        clk,
  input  logic        rstN,
  input  ctlStrobe_t  ctl,
  input  logic        busyIn,
  input  logic [1:0]  busSel,
  input  logic [31:0] busWrData,
  output logic [31:0] busRdData,
  input  logic        sclIn,
  input  logic        sdaIn,
  output logic        sclOe,
  output logic        sdaOe,
  output logic        tick,
  output logic        sclBit,
  output logic        sdaBit,
  output logic        dirWrite,
  output logic        irq
);

  localparam int DIV_W = (SCL_DIV > 1) ? $clog2(SCL_DIV) : 1;
  localparam logic [DIV_W-1:0] DIV_LAST = DIV_W'(SCL_DIV - 1);

  logic [DIV_W-1:0] divCnt;
  logic [1:0]       sclSync;
  logic [1:0]       sdaSync;
  logic [31:0]      addrReg;
  logic [31:0]      dataReg;
  logic             errReg;
  logic [7:0]       txShift;
  logic [7:0]       rxShift;
  logic [7:0]       loadByte;

  // quarter-bit tick generator, idle-reset so the first tick is SCL_DIV away
  always_ff @(posedge clk) begin
    if (!rstN || !ctl.run) divCnt <= '0;
    else if (divCnt == DIV_LAST) divCnt <= '0;
    else divCnt <= divCnt + 1'b1;
  end
  assign tick = ctl.run && (divCnt == DIV_LAST);

  // line synchronizers, idle level high
  always_ff @(posedge clk) begin
    if (!rstN) begin
      sclSync <= 2'b11;
      sdaSync <= 2'b11;
    end else begin
      sclSync <= {sclSync[0], sclIn};
      sdaSync <= {sdaSync[0], sdaIn};
    end
  end
  assign sclBit = sclSync[1];
  assign sdaBit = sdaSync[1];

  always_comb begin
    unique case (ctl.byteSel)
      BYTE_DEVW: loadByte = {DEV_ADDR, 1'b0};
      BYTE_DEVR: loadByte = {DEV_ADDR, 1'b1};
      BYTE_WORD: loadByte = addrReg[7:0];
      default:   loadByte = dataReg[7:0];
    endcase
  end

  // host-visible registers
  always_ff @(posedge clk) begin
    if (!rstN) begin
      addrReg <= '0;
      dataReg <= '0;
      errReg  <= 1'b0;
    end else begin
      if (ctl.wrAddr) addrReg <= busWrData;
      if (ctl.wrData) dataReg <= busWrData;
      else if (ctl.storeRx) dataReg <= {24'b0, rxShift};
      if (ctl.setErr) errReg <= 1'b1;
      else if (ctl.clrErr) errReg <= 1'b0;
    end
  end
  assign dirWrite = addrReg[31];

  // shift registers
  always_ff @(posedge clk) begin
    if (!rstN) begin
      txShift <= '0;
      rxShift <= '0;
    end else begin
      if (ctl.loadShift) txShift <= loadByte;
      else if (ctl.shiftOut) txShift <= {txShift[6:0], 1'b0};
      if (ctl.shiftIn) rxShift <= {rxShift[6:0], sdaBit};
    end
  end

  // open-drain enables and completion pulse
  always_ff @(posedge clk) begin
    if (!rstN) begin
      sclOe <= 1'b0;
      sdaOe <= 1'b0;
      irq   <= 1'b0;
    end else begin
      if (ctl.sclLow) sclOe <= 1'b1;
      else if (ctl.sclRel) sclOe <= 1'b0;
      if (ctl.sdaLow) sdaOe <= 1'b1;
      else if (ctl.sdaRel) sdaOe <= 1'b0;
      else if (ctl.sdaFromShift) sdaOe <= ~txShift[7];
      irq <= ctl.done;
    end
  end

  always_comb begin
    unique case (busSel)
      SEL_ADDR: busRdData = addrReg;
      SEL_DATA: busRdData = dataReg;
      SEL_STAT: busRdData = {30'b0, errReg, busyIn};
      default:  busRdData = '0;
    endcase
  end

  assert_idle_released_R10 : assert property (@(posedge clk) disable iff (!rstN)
    !busyIn |-> (!sclOe && !sdaOe));

  assert_sda_under_low_scl_R10 : assert property (@(posedge clk) disable iff (!rstN)
    ctl.sdaFromShift |-> sclOe);

  assert_irq_pulse_R9 : assert property (@(posedge clk) disable iff (!rstN)
    irq |=> !irq);

  assert_irq_idle_R9 : assert property (@(posedge clk) disable iff (!rstN)
    irq |-> !busyIn);

  assert_err_sticky_R8 : assert property (@(posedge clk) disable iff (!rstN)
    (errReg && !ctl.clrErr) |=> errReg);

  assert_addr_frozen_R6 : assert property (@(posedge clk) disable iff (!rstN)
    busyIn |=> $stable(addrReg));

endmodule

// File: rtl/idrom_control.sv
module idrom_control
  import idrom_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       busWr,
  input  logic [1:0] busSel,
  input  logic       wrDirBit,
  input  logic       wrClrBit,
  input  logic       dirWrite,
  input  logic       tick,
  input  logic       sclBit,
  input  logic       sdaBit,
  output ctlStrobe_t ctl,
  output logic       busy
);

  phase_e     phase;
  logic [1:0] q;
  logic [3:0] bitIdx;
  logic [1:0] byteIdx;
  logic       opRead;
  logic       abortReq;
  logic       isRx;
  logic       lastByte;
  logic       toRestart;
  logic [1:0] nextIdx;

  function automatic byteKind_e kindOf(input logic rd, input logic [1:0] idx);
    unique case (idx)
      2'd0:    kindOf = BYTE_DEVW;
      2'd1:    kindOf = BYTE_WORD;
      2'd2:    kindOf = rd ? BYTE_DEVR : BYTE_DATA;
      default: kindOf = BYTE_DATA;
    endcase
  endfunction

  assign busy      = (phase != PH_IDLE);
  assign isRx      = opRead && (byteIdx == 2'd3);
  assign lastByte  = opRead ? (byteIdx == 2'd3) : (byteIdx == 2'd2);
  assign toRestart = opRead && (byteIdx == 2'd1);
  assign nextIdx   = 2'(byteIdx + 2'd1);

  always_comb begin
    ctl         = '0;
    ctl.byteSel = BYTE_DEVW;
    ctl.run     = busy;
    if (!busy && busWr) begin
      unique case (busSel)
        SEL_ADDR: ctl.wrAddr = 1'b1;
        SEL_DATA: ctl.wrData = 1'b1;
        SEL_STAT: ctl.clrErr = wrClrBit;
        default:  ;
      endcase
    end
    if (tick) begin
      unique case (phase)
        PH_START: begin
          unique case (q)
            2'd0: ctl.sdaRel = 1'b1;
            2'd1: ctl.sclRel = 1'b1;
            2'd2: ctl.sdaLow = 1'b1;
            default: begin
              ctl.sclLow    = 1'b1;
              ctl.loadShift = 1'b1;
              ctl.byteSel   = kindOf(opRead, byteIdx);
            end
          endcase
        end
        PH_BITS: begin
          unique case (q)
            2'd0: begin
              if (isRx || bitIdx == 4'd8) ctl.sdaRel = 1'b1;
              else ctl.sdaFromShift = 1'b1;
            end
            2'd1: ctl.sclRel = 1'b1;
            2'd2: begin
              if (sclBit) begin
                if (isRx && bitIdx != 4'd8) ctl.shiftIn = 1'b1;
                if (!isRx && bitIdx == 4'd8 && sdaBit) ctl.setErr = 1'b1;
              end
            end
            default: begin
              ctl.sclLow = 1'b1;
              if (bitIdx != 4'd8) ctl.shiftOut = 1'b1;
              else begin
                if (isRx) ctl.storeRx = 1'b1;
                if (!abortReq && !lastByte && !toRestart) begin
                  ctl.loadShift = 1'b1;
                  ctl.byteSel   = kindOf(opRead, nextIdx);
                end
              end
            end
          endcase
        end
        PH_STOP: begin
          unique case (q)
            2'd0: ctl.sdaLow = 1'b1;
            2'd1: ctl.sclRel = 1'b1;
            2'd2: ctl.sdaRel = 1'b1;
            default: ctl.done = 1'b1;
          endcase
        end
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      phase    <= PH_IDLE;
      q        <= '0;
      bitIdx   <= '0;
      byteIdx  <= '0;
      opRead   <= 1'b0;
      abortReq <= 1'b0;
    end else if (phase == PH_IDLE) begin
      if (busWr && ((busSel == SEL_ADDR && !wrDirBit) || (busSel == SEL_DATA && dirWrite))) begin
        phase    <= PH_START;
        q        <= '0;
        bitIdx   <= '0;
        byteIdx  <= '0;
        opRead   <= (busSel == SEL_ADDR);
        abortReq <= 1'b0;
      end
    end else if (tick) begin
      unique case (phase)
        PH_START: begin
          q <= 2'(q + 2'd1);
          if (q == 2'd3) begin
            phase  <= PH_BITS;
            bitIdx <= '0;
          end
        end
        PH_BITS: begin
          if (q == 2'd2) begin
            if (sclBit) begin
              q        <= 2'd3;
              abortReq <= abortReq | ctl.setErr;
            end
          end else if (q == 2'd3) begin
            q <= 2'd0;
            if (bitIdx != 4'd8) bitIdx <= bitIdx + 4'd1;
            else if (abortReq || lastByte) phase <= PH_STOP;
            else if (toRestart) begin
              byteIdx <= nextIdx;
              phase   <= PH_START;
            end else begin
              byteIdx <= nextIdx;
              bitIdx  <= '0;
            end
          end else begin
            q <= 2'(q + 2'd1);
          end
        end
        default: begin
          q <= 2'(q + 2'd1);
          if (q == 2'd3) phase <= PH_IDLE;
        end
      endcase
    end
  end

  assert_stretch_hold_R11 : assert property (@(posedge clk) disable iff (!rstN)
    (phase == PH_BITS && q == 2'd2 && tick && !sclBit) |=> (phase == PH_BITS && q == 2'd2));

  assert_done_idle_R5 : assert property (@(posedge clk) disable iff (!rstN)
    ctl.done |=> !busy);

  assert_one_line_op_R10 : assert property (@(posedge clk) disable iff (!rstN)
    $countones({ctl.sdaLow, ctl.sdaRel, ctl.sdaFromShift}) <= 1);

endmodule

// File: rtl/idrom_access.sv
module idrom_access
  import idrom_pkg::*;
#(
  parameter logic [6:0] DEV_ADDR = 7'h50,
  parameter int         SCL_DIV  = 125
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic        busWr,
  input  logic [1:0]  busSel,
  input  logic [31:0] busWrData,
  output logic [31:0] busRdData,
  input  logic        sclIn,
  input  logic        sdaIn,
  output logic        sclOe,
  output logic        sdaOe,
  output logic        irq
);

  ctlStrobe_t ctl;
  logic busy;
  logic tick;
  logic sclBit;
  logic sdaBit;
  logic dirWrite;

  idrom_control uCtl (
    .clk      (clk),
    .rstN     (rstN),
    .busWr    (busWr),
    .busSel   (busSel),
    .wrDirBit (busWrData[31]),
    .wrClrBit (busWrData[1]),
    .dirWrite (dirWrite),
    .tick     (tick),
    .sclBit   (sclBit),
    .sdaBit   (sdaBit),
    .ctl      (ctl),
    .busy     (busy)
  );

  idrom_datapath #(
    .DEV_ADDR (DEV_ADDR),
    .SCL_DIV  (SCL_DIV)
  ) uDp (
    .clk       (clk),
    .rstN      (rstN),
    .ctl       (ctl),
    .busyIn    (busy),
    .busSel    (busSel),
    .busWrData (busWrData),
    .busRdData (busRdData),
    .sclIn     (sclIn),
    .sdaIn     (sdaIn),
    .sclOe     (sclOe),
    .sdaOe     (sdaOe),
    .tick      (tick),
    .sclBit    (sclBit),
    .sdaBit    (sdaBit),
    .dirWrite  (dirWrite),
    .irq       (irq)
  );

endmodule

// File: tb/tb_idrom_access.sv
module tb_idrom_access;

  localparam logic [6:0] DEV = 7'h50;
  localparam int DIV = 4;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic busWr = 1'b0;
  logic [1:0] busSel = 2'd3;
  logic [31:0] busWrData = '0;
  logic [31:0] busRdData;
  logic sclOe, sdaOe, irq;
  logic slvSclLow = 1'b0;
  logic slvSdaLow = 1'b0;
  logic sclBus, sdaBus;

  assign sclBus = !sclOe && !slvSclLow;
  assign sdaBus = !sdaOe && !slvSdaLow;

  idrom_access #(.DEV_ADDR(DEV), .SCL_DIV(DIV)) dut (
    .clk(clk), .rstN(rstN), .busWr(busWr), .busSel(busSel),
    .busWrData(busWrData), .busRdData(busRdData),
    .sclIn(sclBus), .sdaIn(sdaBus), .sclOe(sclOe), .sdaOe(sdaOe), .irq(irq)
  );

  always #5 clk = ~clk;

  int nRun = 0;
  int nFail = 0;
  int cycles = 0;

  // slave model state
  logic [7:0] mem [256];
  logic [7:0] expMem [256];
  logic [7:0] rxLog [8];
  int nLog, startCnt, stopCnt, failAt, txnBytes, stretchCnt;
  bit masterNack, stretchReq;

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    nRun++;
    if (act !== exp) begin
      nFail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic busWrite(input logic [1:0] s, input logic [31:0] d);
    @(negedge clk);
    busSel = s; busWrData = d; busWr = 1'b1;
    @(negedge clk);
    busWr = 1'b0; busSel = 2'd3;
  endtask

  task automatic busRead(input logic [1:0] s, output logic [31:0] v);
    busSel = s;
    #1;
    v = busRdData;
    busSel = 2'd3;
  endtask

  task automatic clearLog();
    nLog = 0; startCnt = 0; stopCnt = 0; masterNack = 1'b0;
  endtask

  task automatic waitDone();
    int n = 0;
    logic [31:0] v;
    while (!irq && n < 5000) begin
      @(negedge clk);
      n++;
    end
    if (!irq) begin
      nRun++; nFail++;
      $display("FAIL R9 irq timeout actual=0 expected=1");
    end else begin
      busRead(2'd2, v);
      chk("R9 busy low with irq", {31'b0, v[0]}, 0);
      @(negedge clk);
      chk("R9 irq single pulse", {31'b0, irq}, 0);
      chk("R10 lines released idle", {30'b0, sclOe, sdaOe}, 0);
    end
  endtask

  task automatic doRead(input logic [7:0] w);
    logic [31:0] v;
    clearLog();
    busWrite(2'd0, {24'b0, w});
    busRead(2'd2, v);
    chk("R5 busy after start", {31'b0, v[0]}, 1);
    waitDone();
    chk("R2 starts", startCnt, 2);
    chk("R2 stops", stopCnt, 1);
    chk("R2 byte count", nLog, 3);
    chk("R2 dev write byte", {24'b0, rxLog[0]}, {24'b0, DEV, 1'b0});
    chk("R2 word byte", {24'b0, rxLog[1]}, {24'b0, w});
    chk("R2 dev read byte", {24'b0, rxLog[2]}, {24'b0, DEV, 1'b1});
    chk("R2 master nack", {31'b0, masterNack}, 1);
    busRead(2'd1, v);
    chk("R3 read data", v, {24'b0, expMem[w]});
  endtask

  task automatic doWrite(input logic [7:0] w, input logic [7:0] d);
    logic [31:0] v;
    clearLog();
    busWrite(2'd0, {1'b1, 23'b0, w});
    repeat (3) @(negedge clk);
    busRead(2'd2, v);
    chk("R4 no txn on write-dir address", {31'b0, v[0]}, 0);
    busWrite(2'd1, {24'hABCDEF, d});
    waitDone();
    expMem[w] = d;
    chk("R4 starts", startCnt, 1);
    chk("R4 stops", stopCnt, 1);
    chk("R4 byte count", nLog, 3);
    chk("R4 dev byte", {24'b0, rxLog[0]}, {24'b0, DEV, 1'b0});
    chk("R4 word byte", {24'b0, rxLog[1]}, {24'b0, w});
    chk("R4 data byte", {24'b0, rxLog[2]}, {24'b0, d});
    chk("R4 eeprom updated", {24'b0, mem[w]}, {24'b0, d});
  endtask

  // bus slave: an EEPROM model sampling lines on the falling clock edge
  initial begin
    int bitCnt = -1;
    int frameIdx = 0;
    bit txMode = 0, pendTx = 0, prevScl = 1, prevSda = 1, scl, sda, ack;
    logic [7:0] sr = '0, txByte = '0, ptr = '0;
    forever begin
      @(negedge clk);
      scl = sclBus; sda = sdaBus;
      if (stretchCnt > 0) begin
        stretchCnt--;
        if (stretchCnt == 0) slvSclLow = 1'b0;
      end
      if (prevScl && scl && prevSda && !sda) begin
        startCnt++; bitCnt = -1; frameIdx = 0; txMode = 0; pendTx = 0; slvSdaLow = 1'b0;
      end else if (prevScl && scl && !prevSda && sda) begin
        stopCnt++; txnBytes = 0; bitCnt = -1; txMode = 0; slvSdaLow = 1'b0;
      end else if (!prevScl && scl) begin
        if (!txMode && bitCnt >= 0 && bitCnt < 8) sr = {sr[6:0], sda};
        if (txMode && bitCnt == 8) masterNack = sda;
      end else if (prevScl && !scl) begin
        bitCnt++;
        if (!txMode) begin
          if (bitCnt == 8) begin
            if (nLog < 8) rxLog[nLog] = sr;
            nLog++;
            ack = (txnBytes != failAt) && (frameIdx != 0 || sr[7:1] == DEV);
            if (ack) begin
              if (frameIdx == 0 && sr[0]) begin pendTx = 1; txByte = mem[ptr]; end
              else if (frameIdx == 1) ptr = sr;
              else if (frameIdx == 2) mem[ptr] = sr;
            end
            slvSdaLow = ack;
            txnBytes++; frameIdx++;
            if (stretchReq) begin
              stretchReq = 0; slvSclLow = 1'b1; stretchCnt = 60;
            end
          end else if (bitCnt == 9) begin
            bitCnt = 0; slvSdaLow = 1'b0;
            if (pendTx) begin txMode = 1; pendTx = 0; slvSdaLow = !txByte[7]; end
          end
        end else begin
          if (bitCnt < 8) slvSdaLow = !txByte[7-bitCnt];
          else if (bitCnt == 8) slvSdaLow = 1'b0;
          else begin bitCnt = 0; txMode = 0; slvSdaLow = 1'b0; end
        end
      end
      prevScl = scl; prevSda = sda;
    end
  end

  initial begin
    forever begin
      @(posedge clk);
      cycles++;
      if (cycles > 150000) begin
        nRun++; nFail++;
        $display("FAIL watchdog actual=%0d expected<150000", cycles);
        $display("[TB] %0d tests run, %0d failed", nRun, nFail);
        $finish;
      end
    end
  end

  initial begin
    logic [31:0] v;
    logic [31:0] r;
    failAt = -1; stretchReq = 0; stretchCnt = 0; txnBytes = 0;
    clearLog();
    for (int i = 0; i < 256; i++) begin
      mem[i] = 8'(i * 37 + 11);
      expMem[i] = mem[i];
    end
    void'($urandom(32'h5eed1234));
    repeat (5) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);

    // R1 reset state
    busRead(2'd2, v); chk("R1 status", v, 0);
    busRead(2'd0, v); chk("R1 address reg", v, 0);
    busRead(2'd1, v); chk("R1 data reg", v, 0);
    busRead(2'd3, v); chk("R5 select 3 reads zero", v, 0);
    chk("R1 irq and lines", {29'b0, irq, sclOe, sdaOe}, 0);

    // R3 stale data during read, R6 writes ignored while busy
    clearLog();
    busWrite(2'd0, 32'h0000_0010);
    busRead(2'd1, v); chk("R3 stale before completion", v, 0);
    busWrite(2'd0, 32'h8000_00AA);
    busWrite(2'd1, 32'h0000_0055);
    busRead(2'd0, v); chk("R6 address write ignored", v, 32'h10);
    waitDone();
    busRead(2'd1, v); chk("R6 data write ignored / R3 read data", v, {24'b0, expMem[8'h10]});
    repeat (20) @(negedge clk);
    chk("R6 no extra transaction", stopCnt, 1);

    doRead(8'h00);
    doWrite(8'hFF, 8'h3C);
    doRead(8'hFF);

    // R4 data write with read direction only stores
    busWrite(2'd1, 32'h1234_5678);
    repeat (3) @(negedge clk);
    busRead(2'd2, v); chk("R4 data write read-dir no start", v, 0);
    busRead(2'd1, v); chk("R4 data write stored", v, 32'h1234_5678);

    // R7 NACK on data byte of a write
    failAt = 2; clearLog();
    busWrite(2'd0, 32'h8000_0020);
    busWrite(2'd1, 32'h0000_00C3);
    waitDone();
    failAt = -1;
    busRead(2'd2, v); chk("R7 error set on data nack", v, 32'h2);
    chk("R7 eeprom unchanged", {24'b0, mem[8'h20]}, {24'b0, expMem[8'h20]});
    chk("R7 stop issued", stopCnt, 1);

    // R8 sticky across a good transaction, clear rules
    doRead(8'h21);
    busRead(2'd2, v); chk("R8 error still set", v, 32'h2);
    busWrite(2'd2, 32'h0000_0001);
    busRead(2'd2, v); chk("R8 clear needs bit1", v, 32'h2);
    busWrite(2'd2, 32'h0000_0002);
    busRead(2'd2, v); chk("R8 error cleared", v, 0);

    // R7 NACK on device address of a read: data register kept
    busRead(2'd1, r);
    failAt = 0; clearLog();
    busWrite(2'd0, 32'h0000_0033);
    waitDone();
    failAt = -1;
    busRead(2'd2, v); chk("R7 error set on address nack", v, 32'h2);
    busRead(2'd1, v); chk("R7 data register unchanged", v, r);
    chk("R7 only address byte sent", nLog, 1);
    chk("R7 stop after address nack", stopCnt, 1);
    busWrite(2'd2, 32'h0000_0002);

    // R11 slave clock stretching
    stretchReq = 1;
    doRead(8'h44);
    busRead(2'd2, v); chk("R11 no error after stretch", v, 0);

    // random mix
    for (int k = 0; k < 24; k++) begin
      r = $urandom;
      if (r[8]) doWrite(r[7:0], r[23:16]);
      else doRead(r[7:0]);
    end
    busRead(2'd2, v); chk("R7 no error in clean traffic", v, 0);

    $display("[TB] %0d tests run, %0d failed", nRun, nFail);
    $finish;
  end

endmodule